// File: doc/BRIEF.md
# Paged Event Fragment Input Buffer

This block takes event fragments from a 32-bit input stream and writes them into a buffer memory. Each word arrives with a valid strobe. The last word of a fragment carries an end flag. The memory is cut into fixed pages of 256 words (1 kByte). Page numbers come from a hardware free list, which is loaded with every page at reset. A fragment longer than one page takes further pages as it grows. Each new page is recorded as the successor of the previous one in a link table, so the whole fragment can be walked in order.

When the end word is accepted, the block pushes a descriptor into a completed-fragment queue. The descriptor holds the event number, the first page, the stored length and two error flags. A consumer uses the queue like this:

1. It reads the descriptor at the head of the queue.
2. It reads the data through a one-cycle read port.
3. It follows the page chain through the link lookup.
4. It pops the descriptor.
5. It hands each page back on the release port once its output transfer is complete.

The first word of every fragment is its event number. Numbers of successive fragments must rise by exactly one. A gap is flagged but the data is kept. A programmable word limit caps each fragment. Words past the limit are dropped and the descriptor is marked oversize. When no page is free, or the completed queue has no room for the end word, input acceptance stalls. Three event counters can be read through a select input.

Top module: `frag_page_buffer`

## Requirements
- R1: After reset `desc_valid` is 0, all three counters read 0, and `in_ready` is 1. The free list holds page numbers 0 to NUM_PAGES-1, and they are handed out in ascending order.
- R2: Word k of a fragment (counting from 0) is stored in its (k/256)-th page, at offset k mod 256. `rd_data` returns the word addressed by `rd_page`/`rd_off` one clock after the address is applied.
- R3: When the end word is accepted, a descriptor is queued. It carries: the fragment's first word as `desc_event`, its first page, and its stored length (at least 1). Descriptors leave in completion order; the head is shown while `desc_valid` is 1 and is removed by `desc_ready`.
- R4: A fragment whose stored words cross a 256-word boundary takes a new page from the free list. The lookup `link_next` for the previous page then returns the new page. A fragment of exactly 256 words uses one page.
- R5: If a word must start a new page and the free list is empty, `in_ready` is 0 and nothing is written. Acceptance resumes on the cycle after a page is released.
- R6: A page given on `rel_page` while `rel_valid` is 1 joins the tail of the free list. Pages are allocated from the free list in first-in first-out order.
- R7: Only the first `max_words` words of a fragment are stored. Later words up to the end word are accepted and dropped. Such a fragment has `desc_oversize` set and `desc_len` equal to `max_words`. A fragment of exactly `max_words` words is not oversize.
- R8: The first fragment after reset never has a sequence error. Every later fragment has `desc_seq_err` set exactly when its event number differs from the previous fragment's event number plus 1 (mod 2^32). The expected number follows the received one, and the data is stored either way.
- R9: Counter select values: 0 counts sequence errors, 1 counts oversize fragments, 2 counts page-allocation stalls, and 3 reads 0. The stall counter rises by one per stall episode (a stalled cycle not preceded by a stalled cycle), however long the stall lasts.
- R10: The sequence and oversize counters rise by one for each fragment that carries the matching flag.
- R11: When the completed queue holds NUM_PAGES descriptors, an end word is refused (`in_ready` 0) until a descriptor is popped. This does not count as a page stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| max_words | input | LEN_W (12) | Largest number of words stored per fragment |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_last | input | 1 | Marks the end word of a fragment |
| in_ready | output | 1 | Input word accepted at this edge when valid |
| desc_valid | output | 1 | Completed queue not empty |
| desc_ready | input | 1 | Pop the head descriptor |
| desc_event | output | 32 | Event number of head fragment |
| desc_first_page | output | PG_W (3) | First page of head fragment |
| desc_len | output | LEN_W (12) | Stored words of head fragment |
| desc_seq_err | output | 1 | Head fragment broke the event sequence |
| desc_oversize | output | 1 | Head fragment exceeded the word limit |
| rel_valid | input | 1 | Release a page |
| rel_page | input | PG_W (3) | Page being released |
| rd_page | input | PG_W (3) | Read page |
| rd_off | input | OFF_W (8) | Read offset in page |
| rd_data | output | 32 | Read word, one clock after address |
| link_page | input | PG_W (3) | Page whose successor is looked up |
| link_next | output | PG_W (3) | Successor page in its fragment's chain |
| cnt_sel | input | 2 | Counter select |
| cnt_value | output | CNT_W (16) | Selected counter value |

## Verification
Some properties are checked on every cycle:
- The free list is never popped while empty.
- The completed queue is never pushed while full.
- Every queued length lies between 1 and the word limit.
- A refused word is always explained by an empty free list or a full queue.
- The stall-episode pulse never fires on two cycles in a row.

Other behaviour only the bench scenarios can show: the data read back word by word, the page chain, the FIFO order of released pages, sequence and oversize flags on chosen event numbers and lengths, and the counter values after a held stall and after a full completed queue.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned ERR_KINDS = 3;

  typedef enum logic [1:0] {
    ERR_SEQ      = 2'd0,
    ERR_OVERSIZE = 2'd1,
    ERR_NOPAGE   = 2'd2,
    ERR_NONE     = 2'd3
  } err_sel_e;

  // next fragment must carry the previous event number plus one
  function automatic logic event_follows(logic [WORD_W-1:0] prev, logic [WORD_W-1:0] cur);
    return cur == prev + 1'b1;
  endfunction

  // true once an open fragment already holds the allowed number of words
  function automatic logic limit_reached(logic busy, int unsigned stored, int unsigned limit);
    return busy && (stored >= limit);
  endfunction

  // offset that closes a page
  function automatic logic page_closes(int unsigned off, int unsigned page_words);
    return off == page_words - 1;
  endfunction
endpackage

// File: rtl/fpb_fifo.sv
module fpb_fifo #(
  parameter int unsigned W       = 8,
  parameter int unsigned DEPTH   = 8,
  parameter bit          PRELOAD = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= PRELOAD ? CW'(DEPTH) : '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  generate
    if (PRELOAD) begin : g_preload
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < int'(DEPTH); i++) mem[i] <= W'(i);
        end else if (do_push) begin
          mem[wr_ptr] <= push_data;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
      end
    end
  endgenerate
endmodule

// File: rtl/fpb_ram.sv
module fpb_ram #(
  parameter int unsigned W        = 32,
  parameter int unsigned DEPTH    = 2048,
  parameter bit          REG_READ = 1'b1
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    if (REG_READ) begin : g_sync
      always_ff @(posedge clk) rdata <= mem[raddr];
    end else begin : g_async
      assign rdata = mem[raddr];
    end
  endgenerate
endmodule

// File: rtl/fpb_err_counters.sv
module fpb_err_counters #(
  parameter int unsigned N     = 3,
  parameter int unsigned CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0]               inc,
  input  logic [$clog2(N+1)-1:0]     sel,
  output logic [CNT_W-1:0]           value
);
  logic [CNT_W-1:0] cnt [N];

  generate
    for (genvar g = 0; g < int'(N); g++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (!rst_n)      cnt[g] <= '0;
        else if (inc[g]) cnt[g] <= cnt[g] + 1'b1;
      end
    end
  endgenerate

  always_comb begin
    value = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (sel == ($clog2(N+1))'(i)) value = cnt[i];
    end
  end
endmodule

// File: rtl/fpb_writer.sv
module fpb_writer
  import fpb_pkg::*;
#(
  parameter int unsigned PG_W       = 3,
  parameter int unsigned OFF_W      = 8,
  parameter int unsigned LEN_W      = 12,
  parameter int unsigned PAGE_WORDS = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LEN_W-1:0]      max_words,
  input  logic                  in_valid,
  input  logic [WORD_W-1:0]     in_data,
  input  logic                  in_last,
  output logic                  in_ready,
  input  logic                  free_empty,
  input  logic [PG_W-1:0]       free_head,
  output logic                  free_pop,
  input  logic                  used_full,
  output logic                  wr_en,
  output logic [PG_W+OFF_W-1:0] wr_addr,
  output logic [WORD_W-1:0]     wr_data,
  output logic                  link_we,
  output logic [PG_W-1:0]       link_addr,
  output logic [PG_W-1:0]       link_data,
  output logic                  used_push,
  output logic [WORD_W-1:0]     push_event,
  output logic [PG_W-1:0]       push_first,
  output logic [LEN_W-1:0]      push_len,
  output logic                  push_seq_err,
  output logic                  push_oversize,
  output logic                  seq_pulse,
  output logic                  ovs_pulse,
  output logic                  ovf_pulse
);
  // fragment state
  logic              in_frag, need_pg, have_prev, stall_d;
  logic [PG_W-1:0]   cur_page, first_pg;
  logic [OFF_W-1:0]  off;
  logic [LEN_W-1:0]  len;
  logic [WORD_W-1:0] ev_r, prev_ev;
  logic              seq_r, ovs_r;

  // per-cycle decisions
  logic              acc, keep, stall_pg, is_first, gap;
  logic [PG_W-1:0]   page_now;
  logic [LEN_W-1:0]  len_now;

  assign keep     = !limit_reached(in_frag, 32'(len), 32'(max_words));
  assign in_ready = !(keep && need_pg && free_empty) && !(in_last && used_full);
  assign acc      = in_valid && in_ready;
  assign stall_pg = in_valid && keep && need_pg && free_empty;
  assign is_first = !in_frag;
  assign gap      = have_prev && !event_follows(prev_ev, in_data);

  assign wr_en    = acc && keep;
  assign free_pop = wr_en && need_pg;
  assign page_now = free_pop ? free_head : cur_page;
  assign wr_addr  = {page_now, off};
  assign wr_data  = in_data;

  assign link_we   = free_pop && in_frag;
  assign link_addr = cur_page;
  assign link_data = free_head;

  assign len_now       = len + LEN_W'(wr_en);
  assign used_push     = acc && in_last;
  assign push_event    = is_first ? in_data : ev_r;
  assign push_first    = is_first ? free_head : first_pg;
  assign push_len      = len_now;
  assign push_seq_err  = is_first ? gap : seq_r;
  assign push_oversize = ovs_r || (acc && !keep);

  assign seq_pulse = acc && is_first && gap;
  assign ovs_pulse = used_push && push_oversize;
  assign ovf_pulse = stall_pg && !stall_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frag   <= 1'b0;
      need_pg   <= 1'b1;
      have_prev <= 1'b0;
      stall_d   <= 1'b0;
      cur_page  <= '0;
      first_pg  <= '0;
      off       <= '0;
      len       <= '0;
      ev_r      <= '0;
      prev_ev   <= '0;
      seq_r     <= 1'b0;
      ovs_r     <= 1'b0;
    end else begin
      stall_d <= stall_pg;
      if (acc && is_first) begin
        have_prev <= 1'b1;
        prev_ev   <= in_data;
      end
      if (wr_en) begin
        cur_page <= page_now;
        off      <= off + 1'b1;
        need_pg  <= page_closes(32'(off), PAGE_WORDS);
      end
      if (acc) begin
        if (in_last) begin
          in_frag <= 1'b0;
          need_pg <= 1'b1;
          off     <= '0;
          len     <= '0;
          seq_r   <= 1'b0;
          ovs_r   <= 1'b0;
        end else begin
          in_frag  <= 1'b1;
          len      <= len_now;
          ev_r     <= push_event;
          first_pg <= push_first;
          seq_r    <= push_seq_err;
          ovs_r    <= push_oversize;
        end
      end
    end
  end
endmodule

// File: rtl/frag_page_buffer.sv
module frag_page_buffer
  import fpb_pkg::*;
#(
  parameter int unsigned NUM_PAGES  = 8,
  parameter int unsigned PAGE_WORDS = 256,
  parameter int unsigned CNT_W      = 16
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic [$clog2(NUM_PAGES*PAGE_WORDS+1)-1:0]    max_words,
  input  logic                                         in_valid,
  input  logic [31:0]                                  in_data,
  input  logic                                         in_last,
  output logic                                         in_ready,
  output logic                                         desc_valid,
  input  logic                                         desc_ready,
  output logic [31:0]                                  desc_event,
  output logic [$clog2(NUM_PAGES)-1:0]                 desc_first_page,
  output logic [$clog2(NUM_PAGES*PAGE_WORDS+1)-1:0]    desc_len,
  output logic                                         desc_seq_err,
  output logic                                         desc_oversize,
  input  logic                                         rel_valid,
  input  logic [$clog2(NUM_PAGES)-1:0]                 rel_page,
  input  logic [$clog2(NUM_PAGES)-1:0]                 rd_page,
  input  logic [$clog2(PAGE_WORDS)-1:0]                rd_off,
  output logic [31:0]                                  rd_data,
  input  logic [$clog2(NUM_PAGES)-1:0]                 link_page,
  output logic [$clog2(NUM_PAGES)-1:0]                 link_next,
  input  logic [1:0]                                   cnt_sel,
  output logic [CNT_W-1:0]                             cnt_value
);
  localparam int unsigned PG_W   = $clog2(NUM_PAGES);
  localparam int unsigned OFF_W  = $clog2(PAGE_WORDS);
  localparam int unsigned LEN_W  = $clog2(NUM_PAGES*PAGE_WORDS+1);
  localparam int unsigned ADDR_W = PG_W + OFF_W;
  localparam int unsigned DESC_W = WORD_W + PG_W + LEN_W + 2;

  // named internal events for the checker
  logic                  free_pop, free_empty, free_full;
  logic [PG_W-1:0]       free_head;
  logic                  used_push, used_full, used_empty;
  logic [DESC_W-1:0]     used_head, used_in;
  logic                  wr_en, link_we;
  logic [ADDR_W-1:0]     wr_addr;
  logic [WORD_W-1:0]     wr_data, push_event;
  logic [PG_W-1:0]       link_addr, link_data, push_first;
  logic [LEN_W-1:0]      push_len;
  logic                  push_seq_err, push_oversize;
  logic                  seq_pulse, ovs_pulse, ovf_pulse;
  logic [ERR_KINDS-1:0]  err_inc;

  fpb_writer #(
    .PG_W(PG_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .PAGE_WORDS(PAGE_WORDS)
  ) u_writer (
    .clk(clk), .rst_n(rst_n), .max_words(max_words),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .free_empty(free_empty), .free_head(free_head), .free_pop(free_pop),
    .used_full(used_full),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .link_we(link_we), .link_addr(link_addr), .link_data(link_data),
    .used_push(used_push), .push_event(push_event), .push_first(push_first),
    .push_len(push_len), .push_seq_err(push_seq_err), .push_oversize(push_oversize),
    .seq_pulse(seq_pulse), .ovs_pulse(ovs_pulse), .ovf_pulse(ovf_pulse)
  );

  fpb_fifo #(.W(PG_W), .DEPTH(NUM_PAGES), .PRELOAD(1'b1)) u_free (
    .clk(clk), .rst_n(rst_n),
    .push(rel_valid), .push_data(rel_page),
    .pop(free_pop), .head(free_head),
    .empty(free_empty), .full(free_full)
  );

  assign used_in = {push_event, push_first, push_len, push_seq_err, push_oversize};

  fpb_fifo #(.W(DESC_W), .DEPTH(NUM_PAGES), .PRELOAD(1'b0)) u_used (
    .clk(clk), .rst_n(rst_n),
    .push(used_push), .push_data(used_in),
    .pop(desc_ready), .head(used_head),
    .empty(used_empty), .full(used_full)
  );

  assign desc_valid = !used_empty;
  assign {desc_event, desc_first_page, desc_len, desc_seq_err, desc_oversize} = used_head;

  fpb_ram #(.W(WORD_W), .DEPTH(NUM_PAGES*PAGE_WORDS), .REG_READ(1'b1)) u_data (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr({rd_page, rd_off}), .rdata(rd_data)
  );

  fpb_ram #(.W(PG_W), .DEPTH(NUM_PAGES), .REG_READ(1'b0)) u_link (
    .clk(clk), .we(link_we), .waddr(link_addr), .wdata(link_data),
    .raddr(link_page), .rdata(link_next)
  );

  always_comb begin
    err_inc = '0;
    err_inc[ERR_SEQ]      = seq_pulse;
    err_inc[ERR_OVERSIZE] = ovs_pulse;
    err_inc[ERR_NOPAGE]   = ovf_pulse;
  end

  fpb_err_counters #(.N(ERR_KINDS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(err_inc), .sel(cnt_sel), .value(cnt_value)
  );
endmodule

// File: rtl/frag_page_buffer_chk.sv
module frag_page_buffer_chk #(
  parameter int unsigned LEN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             free_pop,
  input logic             free_empty,
  input logic             used_push,
  input logic             used_full,
  input logic [LEN_W-1:0] push_len,
  input logic [LEN_W-1:0] max_words,
  input logic             ovf_pulse
);
  assert_free_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    free_pop |-> !free_empty);

  assert_used_push_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
    used_push |-> !used_full);

  assert_len_within_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (used_push && max_words != '0) |-> (push_len <= max_words));

  assert_len_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    used_push |-> (push_len != '0));

  assert_refusal_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (free_empty || used_full));

  assert_stall_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);
endmodule

bind frag_page_buffer frag_page_buffer_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .free_pop(free_pop), .free_empty(free_empty),
  .used_push(used_push), .used_full(used_full),
  .push_len(push_len), .max_words(max_words), .ovf_pulse(ovf_pulse)
);

// File: tb/sim_frag_page_buffer.sv
`timescale 1ns/1ps
module sim_frag_page_buffer;
  localparam int NP = 8;
  localparam int PW = 256;
  localparam int PG_W = 3, OFF_W = 8, LEN_W = 12, CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LEN_W-1:0] max_words = LEN_W'(2048);
  logic in_valid = 0, in_last = 0, in_ready;
  logic [31:0] in_data = '0;
  logic desc_valid, desc_ready = 0, desc_seq_err, desc_oversize;
  logic [31:0] desc_event, rd_data;
  logic [PG_W-1:0] desc_first_page, rel_page = '0, rd_page = '0, link_page = '0, link_next;
  logic [LEN_W-1:0] desc_len;
  logic rel_valid = 0;
  logic [OFF_W-1:0] rd_off = '0;
  logic [1:0] cnt_sel = '0;
  logic [CNT_W-1:0] cnt_value;

  frag_page_buffer u0 (.*);

  always #10 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  int free_q[$];
  int last_pages[$];
  logic [31:0] words [0:2047];
  logic [31:0] q_ev[$];
  int q_first[$], q_len[$];
  bit q_seq[$], q_ovs[$];
  bit have_prev = 0;
  logic [31:0] prev_ev = '0;
  int n_seq = 0, n_ovs = 0, n_ovf = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int stored_len(int len, int lim);
    return (len > lim) ? lim : len;
  endfunction

  function automatic bit breaks_seq(bit hp, logic [31:0] prev, logic [31:0] ev);
    return hp && (ev != prev + 32'd1);
  endfunction

  task automatic send_frag(input logic [31:0] ev, input int len);
    int st;
    st = stored_len(len, int'(max_words));
    last_pages.delete();
    for (int k = 0; k < len; k++) begin
      logic [31:0] w;
      w = (k == 0) ? ev : $urandom;
      if (k < st) words[k] = w;
      @(negedge clk);
      in_valid = 1; in_data = w; in_last = (k == len - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      if (k < st && (k % PW) == 0) last_pages.push_back(free_q.pop_front());
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    q_ev.push_back(ev); q_first.push_back(last_pages[0]); q_len.push_back(st);
    q_seq.push_back(breaks_seq(have_prev, prev_ev, ev));
    q_ovs.push_back(len > int'(max_words));
    if (breaks_seq(have_prev, prev_ev, ev)) n_seq++;
    if (len > int'(max_words)) n_ovs++;
    have_prev = 1; prev_ev = ev;
  endtask

  task automatic pop_check(input bit do_data);
    int n;
    @(negedge clk);
    chk("R3 desc_valid", desc_valid, 1);
    chk("R3 desc_event", desc_event, q_ev[0]);
    chk("R3/R6 desc_first_page", desc_first_page, q_first[0]);
    chk("R3/R7 desc_len", desc_len, q_len[0]);
    chk("R8 desc_seq_err", desc_seq_err, q_seq[0]);
    chk("R7 desc_oversize", desc_oversize, q_ovs[0]);
    n = q_len[0];
    void'(q_ev.pop_front()); void'(q_first.pop_front()); void'(q_len.pop_front());
    void'(q_seq.pop_front()); void'(q_ovs.pop_front());
    if (do_data) begin
      rd_page = PG_W'(last_pages[0]); rd_off = '0;
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        chk("R2 stored word", rd_data, words[k]);
        if (k + 1 < n) begin
          rd_page = PG_W'(last_pages[(k + 1) / PW]);
          rd_off  = OFF_W'((k + 1) % PW);
        end
      end
      for (int i = 0; i + 1 < last_pages.size(); i++) begin
        link_page = PG_W'(last_pages[i]); #1;
        chk("R4 link_next", link_next, last_pages[i + 1]);
      end
      chk("R4 page count", last_pages.size(), (n + PW - 1) / PW);
    end
    desc_ready = 1;
    @(negedge clk);
    desc_ready = 0;
  endtask

  task automatic release_list(input int pages[$]);
    foreach (pages[i]) begin
      @(negedge clk);
      rel_valid = 1; rel_page = PG_W'(pages[i]);
      free_q.push_back(pages[i]);
    end
    @(negedge clk);
    rel_valid = 0;
  endtask

  task automatic check_counters(string tag);
    cnt_sel = 2'd0; #1; chk({tag, " R10 seq counter"}, cnt_value, n_seq);
    cnt_sel = 2'd1; #1; chk({tag, " R10 oversize counter"}, cnt_value, n_ovs);
    cnt_sel = 2'd2; #1; chk({tag, " R9 stall counter"}, cnt_value, n_ovf);
    cnt_sel = 2'd3; #1; chk({tag, " R9 unused select"}, cnt_value, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int pa[$], pb[$], rel[$];
    logic [31:0] ev;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NP; i++) free_q.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 desc_valid after reset", desc_valid, 0);
    chk("R1 in_ready after reset", in_ready, 1);
    check_counters("R1");

    // directed shapes
    max_words = LEN_W'(2048);
    send_frag(32'd100, 1);   pop_check(1); release_list(last_pages); // R1 page 0 first
    send_frag(32'd101, 256); pop_check(1); release_list(last_pages); // R4 exactly one page
    send_frag(32'd102, 257); pop_check(1); release_list(last_pages); // R4 two pages
    send_frag(32'd200, 10);  pop_check(1); release_list(last_pages); // R8 gap
    max_words = LEN_W'(300);
    send_frag(32'd201, 300); pop_check(1); release_list(last_pages); // R7 at limit
    send_frag(32'd202, 301); pop_check(1); release_list(last_pages); // R7 one over
    check_counters("directed");

    // random fragments
    max_words = LEN_W'(600);
    ev = 32'd500;
    for (int f = 0; f < 25; f++) begin
      ev = (($urandom % 5) == 0) ? $urandom : ev + 32'd1;
      send_frag(ev, 1 + int'($urandom % 700));
      pop_check(1);
      rel = last_pages;
      if (f % 2 == 1) rel.reverse();   // R6 release order drives allocation order
      release_list(rel);
    end
    check_counters("random");

    // R5/R9 stall on empty free list
    max_words = LEN_W'(2048);
    send_frag(ev + 32'd1, 1024); pa = last_pages;
    send_frag(ev + 32'd2, 1024); pb = last_pages;
    fork
      send_frag(ev + 32'd3, 3);
      begin
        repeat (4) @(negedge clk);
        #2;
        chk("R5 in_ready low with no free page", in_ready, 0);
        n_ovf++;
        cnt_sel = 2'd2; #1;
        chk("R9 stall counted once", cnt_value, n_ovf);
        repeat (3) @(negedge clk);
        #2;
        chk("R9 stall counted once while held", cnt_value, n_ovf);
        rel.delete(); rel.push_back(pa[0]);
        release_list(rel);
      end
    join
    pop_check(0); pop_check(0); pop_check(1);
    pa.delete(0);
    release_list(pa); release_list(pb); release_list(last_pages);
    check_counters("stall");

    // R11 completed queue full
    for (int f = 0; f < NP; f++) begin
      ev = ev + 32'd1;
      send_frag(ev, 1);
      release_list(last_pages);
    end
    fork
      send_frag(ev + 32'd1, 1);
      begin
        repeat (3) @(negedge clk);
        #2;
        chk("R11 end word refused while queue full", in_ready, 0);
        pop_check(0);
      end
    join
    for (int f = 0; f < NP; f++) pop_check(0);
    release_list(last_pages);
    @(negedge clk);
    chk("R3 queue drained", desc_valid, 0);
    check_counters("R11");
    finish_run();
  end
endmodule